// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block turns the operands of a load or store into a data-space address. The caller supplies a request strobe, the addressing mode, a 16-bit pointer, a 6-bit displacement and a 16-bit direct address. The caller has already read the pointer from one of three register pairs. The block returns the effective address and the value to write back into the pointer, with its enable. It also returns the index of the pair's low-byte working register and one-hot region selects. Those selects cover the working-register file, the I/O window and the on-chip SRAM. For I/O accesses it also gives the 6-bit I/O index.

The block holds the 8-bit stack pointer. A push stores at the current stack pointer and then decrements it. A pop first increments the pointer and then reads at the new value. Software can load the stack pointer directly, and that load wins over a push or pop in the same cycle. The address and write-back paths are combinational. The stack pointer is the only register in the block.

Top module: `dag_top`

## Requirements
- R1: An effective address in 0x0000–0x001F asserts `sel_reg` only.
- R2: An effective address in 0x0020–0x005F asserts `sel_io` only, and `io_idx` equals the address minus 0x20.
- R3: An effective address in 0x0060–0x00DF asserts `sel_sram` only. Any address above 0x00DF asserts no select.
- R4: Mode 0 (direct) gives `ea` = `direct_addr` and no pointer write-back.
- R5: Mode 1 (plain indirect) and the reserved mode 7 give `ea` = `ptr_val` and no write-back.
- R6: Mode 2 (post-increment) gives `ea` = `ptr_val`, with `ptr_wb` = `ptr_val`+1 and `ptr_wb_en` high. The value wraps from 0xFFFF to 0x0000.
- R7: Mode 3 (pre-decrement) gives `ea` = `ptr_wb` = `ptr_val`−1, with `ptr_wb_en` high. The value wraps from 0x0000 to 0xFFFF.
- R8: Mode 4 (displacement) with `ptr_sel` 1 or 2 gives `ea` = `ptr_val` + the zero-extended `disp`, modulo 2^16. With `ptr_sel` 0 or 3 the displacement is ignored and `ea` = `ptr_val`. Mode 4 never writes back.
- R9: Mode 5 (push) with `req_valid` high gives `ea` = the zero-extended stack pointer. The stack pointer is one lower after the next clock edge, modulo 256.
- R10: Mode 6 (pop) with `req_valid` high gives `ea` = the zero-extended stack pointer+1. The stack pointer is one higher after the next clock edge, modulo 256.
- R11: `sp_wr_en` loads `sp_wr_data` into the stack pointer at the next edge. This load takes priority over a push or pop in the same cycle.
- R12: After reset `sp_out` is 0xDF. With `req_valid` low, `ptr_wb_en` stays low and the stack pointer holds its value unless it is loaded.
- R13: `ptr_lo_reg` is 26 for `ptr_sel` 0 (X) and 3, 28 for 1 (Y), and 30 for 2 (Z).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| mode | input | 3 | Addressing mode, encoded 0..7 as in the requirements |
| ptr_sel | input | 2 | Pointer pair: 0 X, 1 Y, 2 Z, 3 reserved (acts as X) |
| ptr_val | input | 16 | Current value of the selected pointer |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Address for direct mode |
| sp_wr_en | input | 1 | Load the stack pointer |
| sp_wr_data | input | 8 | Value to load into the stack pointer |
| ea | output | 16 | Effective data-space address |
| ptr_wb | output | 16 | Updated pointer value |
| ptr_wb_en | output | 1 | Write `ptr_wb` back to the pair |
| ptr_lo_reg | output | 5 | Working-register index of the pair's low byte |
| sel_reg | output | 1 | Working-register region selected |
| sel_io | output | 1 | I/O region selected |
| sel_sram | output | 1 | SRAM region selected |
| io_idx | output | 6 | I/O index within the I/O window |
| sp_out | output | 8 | Current stack pointer |

## Verification
The effective address, write-back, pair index, selects and I/O index are combinational, so each one is due in the cycle its inputs are applied. The bench drives inputs on the falling edge and compares these outputs a quarter period later. A stack-pointer change from a push, pop or load appears one rising edge after the request. The reference model therefore updates its stack pointer only at that rising edge and compares `sp_out` on the next falling-edge sample. Directed cases cover every region boundary, both pointer wraps, the ignored displacement on X, and a load colliding with a push. A long random run follows.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int ADDR_W    = 16;
    localparam int SP_W      = 8;
    localparam int DISP_W    = 6;
    localparam int IO_W      = 6;
    localparam int REG_IDX_W = 5;

    localparam logic [ADDR_W-1:0] IO_BASE   = 16'h0020;
    localparam logic [ADDR_W-1:0] SRAM_BASE = 16'h0060;
    localparam logic [ADDR_W-1:0] SRAM_LAST = 16'h00DF;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_PLAIN   = 3'd1,
        AM_POSTINC = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_DISP    = 3'd4,
        AM_PUSH    = 3'd5,
        AM_POP     = 3'd6,
        AM_RSV     = 3'd7
    } addr_mode_e;

    typedef enum logic [1:0] {
        PS_X   = 2'd0,
        PS_Y   = 2'd1,
        PS_Z   = 2'd2,
        PS_RSV = 2'd3
    } ptr_sel_e;

    typedef struct packed {
        logic in_reg;
        logic in_io;
        logic in_sram;
    } region_t;

    function automatic logic [REG_IDX_W-1:0] pair_low_reg(ptr_sel_e s);
        case (s)
            PS_Y:    return 5'd28;
            PS_Z:    return 5'd30;
            default: return 5'd26;
        endcase
    endfunction

    function automatic logic allows_disp(ptr_sel_e s);
        return (s == PS_Y) || (s == PS_Z);
    endfunction

endpackage

// File: rtl/dag_ea_calc.sv
module dag_ea_calc
    import dag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SP_W,
    parameter int DW = DISP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  addr_mode_e           mode,
    input  ptr_sel_e             psel,
    input  logic [AW-1:0]        ptr,
    input  logic [DW-1:0]        disp,
    input  logic [AW-1:0]        direct,
    input  logic [SW-1:0]        sp,
    output logic [AW-1:0]        ea,
    output logic [AW-1:0]        wb_val,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] pair_lo
);

    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [SW-1:0] ONE_S = SW'(1);

    logic [AW-1:0] ptr_inc, ptr_dec, ptr_off, disp_ext;
    logic [SW-1:0] sp_inc;

    assign disp_ext = {{(AW-DW){1'b0}}, disp};
    assign ptr_inc  = ptr + ONE_A;
    assign ptr_dec  = ptr - ONE_A;
    assign ptr_off  = allows_disp(psel) ? (ptr + disp_ext) : ptr;
    assign sp_inc   = sp + ONE_S;
    assign pair_lo  = pair_low_reg(psel);

    always_comb begin
        ea     = ptr;
        wb_val = ptr;
        wb_en  = 1'b0;
        case (mode)
            AM_DIRECT:  ea = direct;
            AM_POSTINC: begin
                wb_val = ptr_inc;
                wb_en  = valid;
            end
            AM_PREDEC:  begin
                ea     = ptr_dec;
                wb_val = ptr_dec;
                wb_en  = valid;
            end
            AM_DISP:    ea = ptr_off;
            AM_PUSH:    ea = {{(AW-SW){1'b0}}, sp};
            AM_POP:     ea = {{(AW-SW){1'b0}}, sp_inc};
            default:    ea = ptr;
        endcase
    end

    AST_WB_ONLY_STEP_MODES: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (valid && (mode == AM_POSTINC || mode == AM_PREDEC))) else $error("wb mode"); // R6
    AST_PREDEC_EA_IS_WB: assert property (@(posedge clk) disable iff (rst)
        (wb_en && mode == AM_PREDEC) |-> (ea == wb_val)) else $error("predec"); // R7
    AST_POSTINC_EA_IS_PTR: assert property (@(posedge clk) disable iff (rst)
        (wb_en && mode == AM_POSTINC) |-> (ea == ptr)) else $error("postinc"); // R6
    AST_DISP_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_DISP) |-> !wb_en) else $error("disp wb"); // R8
    AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !wb_en) else $error("idle wb"); // R12

endmodule

// File: rtl/dag_region_dec.sv
module dag_region_dec
    import dag_pkg::*;
#(
    parameter int              AW      = ADDR_W,
    parameter int              IW      = IO_W,
    parameter logic [AW-1:0]   IO_LO   = IO_BASE,
    parameter logic [AW-1:0]   SRAM_LO = SRAM_BASE,
    parameter logic [AW-1:0]   SRAM_HI = SRAM_LAST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ea,
    output region_t       region,
    output logic [IW-1:0] io_idx
);

    logic [AW-1:0] io_off;

    assign io_off         = ea - IO_LO;
    assign io_idx         = io_off[IW-1:0];
    assign region.in_reg  = (ea < IO_LO);
    assign region.in_io   = (ea >= IO_LO) && (ea < SRAM_LO);
    assign region.in_sram = (ea >= SRAM_LO) && (ea <= SRAM_HI);

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({region.in_reg, region.in_io, region.in_sram})) else $error("onehot"); // R3
    AST_IO_IDX_FITS: assert property (@(posedge clk) disable iff (rst)
        region.in_io |-> (io_off[AW-1:IW] == '0)) else $error("io idx"); // R2

endmodule

// File: rtl/dag_stack_ptr.sv
module dag_stack_ptr
    import dag_pkg::*;
#(
    parameter int            SW   = SP_W,
    parameter logic [SW-1:0] INIT = 8'hDF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  addr_mode_e    mode,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_val,
    output logic [SW-1:0] sp
);

    localparam logic [SW-1:0] ONE_S = SW'(1);

    logic [SW-1:0] sp_nxt;

    always_comb begin
        sp_nxt = sp;
        if (ld_en)
            sp_nxt = ld_val;
        else if (valid && mode == AM_PUSH)
            sp_nxt = sp - ONE_S;
        else if (valid && mode == AM_POP)
            sp_nxt = sp + ONE_S;
    end

    always_ff @(posedge clk) begin
        if (rst) sp <= INIT;
        else     sp <= sp_nxt;
    end

    AST_SP_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && valid && mode == AM_PUSH) |=> (sp == $past(sp) - ONE_S)) else $error("push"); // R9
    AST_SP_POP_INC: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && valid && mode == AM_POP) |=> (sp == $past(sp) + ONE_S)) else $error("pop"); // R10
    AST_SP_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (sp == $past(ld_val))) else $error("load"); // R11
    AST_SP_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !valid) |=> $stable(sp)) else $error("hold"); // R12

endmodule

// File: rtl/dag_top.sv
module dag_top
    import dag_pkg::*;
#(
    parameter int                AW      = ADDR_W,
    parameter int                SW      = SP_W,
    parameter int                DW      = DISP_W,
    parameter int                IW      = IO_W,
    parameter logic [SP_W-1:0]   SP_INIT = 8'hDF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [2:0]           mode,
    input  logic [1:0]           ptr_sel,
    input  logic [AW-1:0]        ptr_val,
    input  logic [DW-1:0]        disp,
    input  logic [AW-1:0]        direct_addr,
    input  logic                 sp_wr_en,
    input  logic [SW-1:0]        sp_wr_data,
    output logic [AW-1:0]        ea,
    output logic [AW-1:0]        ptr_wb,
    output logic                 ptr_wb_en,
    output logic [REG_IDX_W-1:0] ptr_lo_reg,
    output logic                 sel_reg,
    output logic                 sel_io,
    output logic                 sel_sram,
    output logic [IW-1:0]        io_idx,
    output logic [SW-1:0]        sp_out
);

    addr_mode_e am;
    ptr_sel_e   ps;
    region_t    rgn;

    assign am = addr_mode_e'(mode);
    assign ps = ptr_sel_e'(ptr_sel);

    dag_ea_calc #(.AW(AW), .SW(SW), .DW(DW)) u_ea (
        .clk     (clk),
        .rst     (rst),
        .valid   (req_valid),
        .mode    (am),
        .psel    (ps),
        .ptr     (ptr_val),
        .disp    (disp),
        .direct  (direct_addr),
        .sp      (sp_out),
        .ea      (ea),
        .wb_val  (ptr_wb),
        .wb_en   (ptr_wb_en),
        .pair_lo (ptr_lo_reg)
    );

    dag_region_dec #(.AW(AW), .IW(IW)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .ea     (ea),
        .region (rgn),
        .io_idx (io_idx)
    );

    dag_stack_ptr #(.SW(SW), .INIT(SP_INIT)) u_sp (
        .clk    (clk),
        .rst    (rst),
        .valid  (req_valid),
        .mode   (am),
        .ld_en  (sp_wr_en),
        .ld_val (sp_wr_data),
        .sp     (sp_out)
    );

    assign sel_reg  = rgn.in_reg;
    assign sel_io   = rgn.in_io;
    assign sel_sram = rgn.in_sram;

    AST_PUSH_EA_IS_SP: assert property (@(posedge clk) disable iff (rst)
        (am == AM_PUSH) |-> (ea == {{(AW-SW){1'b0}}, sp_out})) else $error("push ea"); // R9
    AST_DIRECT_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (am == AM_DIRECT) |-> (!ptr_wb_en && ea == direct_addr)) else $error("direct"); // R4

endmodule

// File: tb/dag_top_tb.sv
module dag_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  mode;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_val;
    logic [5:0]  disp;
    logic [15:0] direct_addr;
    logic        sp_wr_en;
    logic [7:0]  sp_wr_data;
    logic [15:0] ea;
    logic [15:0] ptr_wb;
    logic        ptr_wb_en;
    logic [4:0]  ptr_lo_reg;
    logic        sel_reg, sel_io, sel_sram;
    logic [5:0]  io_idx;
    logic [7:0]  sp_out;

    int checks = 0;
    int errors = 0;
    int model_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    dag_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .ptr_sel(ptr_sel),
        .ptr_val(ptr_val), .disp(disp), .direct_addr(direct_addr), .sp_wr_en(sp_wr_en),
        .sp_wr_data(sp_wr_data), .ea(ea), .ptr_wb(ptr_wb), .ptr_wb_en(ptr_wb_en),
        .ptr_lo_reg(ptr_lo_reg), .sel_reg(sel_reg), .sel_io(sel_io), .sel_sram(sel_sram),
        .io_idx(io_idx), .sp_out(sp_out)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic step(input bit v, input int m, input int s, input int p, input int d,
                        input int da, input bit we, input int wd);
        int e_ea, e_wb, e_lo;
        bit e_en, e_r, e_i, e_s;
        string mt, rt, st;
        @(negedge clk);
        req_valid = v; mode = 3'(m); ptr_sel = 2'(s); ptr_val = 16'(p);
        disp = 6'(d); direct_addr = 16'(da); sp_wr_en = we; sp_wr_data = 8'(wd);
        #(CLK_PERIOD/4);
        e_wb = p; e_en = 1'b0;
        case (m)
            0: begin e_ea = da; mt = "R4"; end
            2: begin e_ea = p; e_wb = (p + 1) & 16'hFFFF; e_en = v; mt = "R6"; end
            3: begin e_ea = (p - 1) & 16'hFFFF; e_wb = e_ea; e_en = v; mt = "R7"; end
            4: begin e_ea = (s == 1 || s == 2) ? ((p + d) & 16'hFFFF) : p; mt = "R8"; end
            5: begin e_ea = model_sp; mt = "R9"; end
            6: begin e_ea = (model_sp + 1) & 8'hFF; mt = "R10"; end
            default: begin e_ea = p; mt = "R5"; end
        endcase
        if (!v) mt = (m == 0 || m == 1 || m == 7) ? mt : "R12";
        e_lo = (s == 1) ? 28 : (s == 2) ? 30 : 26;
        e_r = (e_ea < 16'h20);
        e_i = (e_ea >= 16'h20) && (e_ea < 16'h60);
        e_s = (e_ea >= 16'h60) && (e_ea <= 16'hDF);
        rt = e_r ? "R1" : e_i ? "R2" : "R3";
        if (m != 0 || v) check(mt, "ea", int'(ea), e_ea);
        else             check("R4", "ea", int'(ea), e_ea);
        check(mt, "ptr_wb_en", int'(ptr_wb_en), int'(e_en));
        if (e_en) check(mt, "ptr_wb", int'(ptr_wb), e_wb);
        check("R13", "ptr_lo_reg", int'(ptr_lo_reg), e_lo);
        check(rt, "selects", int'({sel_reg, sel_io, sel_sram}), int'({e_r, e_i, e_s}));
        if (e_i) check("R2", "io_idx", int'(io_idx), e_ea - 16'h20);
        check("R12", "sp_out", int'(sp_out), model_sp);
        @(posedge clk);
        if (we)                 model_sp = wd & 8'hFF;
        else if (v && m == 5)   model_sp = (model_sp - 1) & 8'hFF;
        else if (v && m == 6)   model_sp = (model_sp + 1) & 8'hFF;
        #1;
        st = we ? "R11" : (v && m == 5) ? "R9" : (v && m == 6) ? "R10" : "R12";
        check(st, "sp after edge", int'(sp_out), model_sp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R12 watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 0; mode = 0; ptr_sel = 0; ptr_val = 0; disp = 0;
        direct_addr = 0; sp_wr_en = 0; sp_wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_sp = 8'hDF;
        // R12 reset value and idle behaviour
        check("R12", "sp reset", int'(sp_out), 8'hDF);
        step(0, 2, 0, 16'h1234, 0, 0, 0, 0);
        step(0, 5, 0, 0, 0, 0, 0, 0);
        // R1 R2 R3 region boundaries through direct mode (R4)
        step(1, 0, 0, 0, 0, 16'h001F, 0, 0);
        step(1, 0, 0, 0, 0, 16'h0020, 0, 0);
        step(1, 0, 0, 0, 0, 16'h005F, 0, 0);
        step(1, 0, 0, 0, 0, 16'h0060, 0, 0);
        step(1, 0, 0, 0, 0, 16'h00DF, 0, 0);
        step(1, 0, 0, 0, 0, 16'h00E0, 0, 0);
        step(1, 0, 0, 0, 0, 16'hFFFF, 0, 0);
        // R5 plain and reserved mode
        step(1, 1, 1, 16'h0045, 0, 0, 0, 0);
        step(1, 7, 2, 16'h0080, 0, 0, 0, 0);
        // R6 post-increment with wrap
        step(1, 2, 0, 16'h0030, 0, 0, 0, 0);
        step(1, 2, 2, 16'hFFFF, 0, 0, 0, 0);
        // R7 pre-decrement with wrap
        step(1, 3, 1, 16'h0061, 0, 0, 0, 0);
        step(1, 3, 0, 16'h0000, 0, 0, 0, 0);
        // R8 displacement: Y and Z use it, X and reserved ignore it
        step(1, 4, 1, 16'h0020, 63, 0, 0, 0);
        step(1, 4, 2, 16'hFFF0, 32, 0, 0, 0);
        step(1, 4, 0, 16'h0010, 63, 0, 0, 0);
        step(1, 4, 3, 16'h0010, 5, 0, 0, 0);
        // R9 R10 push and pop
        step(1, 5, 0, 0, 0, 0, 0, 0);
        step(1, 5, 0, 0, 0, 0, 0, 0);
        step(1, 6, 0, 0, 0, 0, 0, 0);
        // R11 load alone, then load colliding with push and pop
        step(0, 0, 0, 0, 0, 0, 1, 8'h00);
        step(1, 5, 0, 0, 0, 0, 0, 0);
        step(1, 5, 0, 0, 0, 0, 1, 8'h70);
        step(1, 6, 0, 0, 0, 0, 1, 8'hFF);
        step(1, 6, 0, 0, 0, 0, 0, 0);
        // random traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            int rm;
            rm = int'($urandom_range(0, 7));
            step(($urandom_range(0, 7) != 0), rm, int'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 16'hFF))
                                             : int'($urandom_range(0, 16'hFFFF)),
                 int'($urandom_range(0, 63)),
                 int'($urandom_range(0, 16'h1FF)),
                 ($urandom_range(0, 15) == 0), int'($urandom_range(0, 255)));
        end
        finish_run();
    end

endmodule